// File: doc/BRIEF.md
# Stalled-Rotor Guard with Automatic Retry

This block watches the level of the first Hall sensor of a three-phase fan motor. It decides whether the rotor is turning or held still. A digital accumulator stands in for a timing capacitor. While the motor runs, the accumulator climbs at a steady rate on every prescaler tick. Each change of the Hall level knocks it down by a fixed amount. A turning rotor therefore keeps it below an upper level.

If edges stop arriving, or arrive too slowly, the accumulator reaches the upper level. When that happens, the block blocks drive and raises the locked flag. It then ramps the accumulator slowly down to a lower level, which is the off window. Once there, it ramps quickly back up, which is a short retry window with drive permitted. The falling rate is about one fourteenth of the rising rate, so the off window is roughly fourteen times the retry window. This cycle repeats until a Hall edge is seen during a retry window. That edge clears the flag, and the block returns to normal supervision.

The stop state (run low) clears everything and removes drive. Tying the enable low turns the protection off entirely.

Top module: `stall_guard`

## Requirements
- R1: While `run` is low, `drive_ok` is low. `locked` is low from the first clock edge after `run` is seen low. The accumulator restarts from zero, so the next start again permits drive for the full first-engagement time.
- R2: While `prot_en` is low, `drive_ok` equals `run` and `locked` stays low. After `prot_en` rises with `run` high, protection engages after the full first-engagement time.
- R3: With `run` and `prot_en` high and no Hall edges from the start, `drive_ok` stays high for ceil(HI_LVL/UP_STEP)·TICK_DIV clock edges (120 with defaults). It then falls, and `locked` rises at the same edge.
- R4: Each off window lasts ceil((HI_LVL−LO_LVL)/DN_STEP)·TICK_DIV clock edges (1120 with defaults). Throughout it, `locked` stays high and `drive_ok` stays low.
- R5: Each retry window lasts ceil((HI_LVL−LO_LVL)/UP_STEP)·TICK_DIV clock edges (80 with defaults), with `locked` still high. The retry and off windows alternate for as long as no Hall edge arrives.
- R6: Hall edges during an off window change neither its length nor the `locked` flag.
- R7: Hall edges closer together than EDGE_DROP/UP_STEP ticks (a toggle period of 16 clocks or less with defaults) keep `locked` low and `drive_ok` high indefinitely.
- R8: Hall edges spaced 100 clocks or more apart (defaults) let the accumulator reach the upper level, and `locked` rises.
- R9: A Hall edge during a retry window clears `locked` three clock edges after the input changes (two synchronizer stages plus the register). `drive_ok` stays high.
- R10: `locked` never rises while drive is permitted.
- R11: After reset, `locked` is low and, with `run` low, `drive_ok` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hall_in | input | 1 | Level of the first Hall sensor (asynchronous) |
| prot_en | input | 1 | High enables stall protection; low holds the accumulator at zero |
| run | input | 1 | High starts the motor, low selects stop |
| drive_ok | output | 1 | High when the driver may energise the low-side switches |
| locked | output | 1 | High while the rotor is judged stalled |

## Verification
The hardest case to reach is a Hall edge landing inside a retry window. That window opens only after the first engagement and a full off window have passed. The bench therefore runs the first ramp and the off window to completion. It detects the rising edge of `drive_ok` while `locked` is high, and only then toggles the Hall input. Random toggle periods drawn from two bands then test both sides of the boundary between an edge rate that is fast enough and one that is too slow.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
  typedef enum logic {
    PH_ON  = 1'b0,
    PH_OFF = 1'b1
  } phase_t;
endpackage

// File: rtl/sg_edge_sync.sv
module sg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  // Shift chain: stages 0..STAGES-1 synchronise, stage STAGES holds the prior value
  genvar gi;
  generate
    for (gi = 0; gi <= STAGES; gi++) begin : g_chain
      if (gi == 0) begin : g_first
        assign sh_d[gi] = din;
      end else begin : g_rest
        assign sh_d[gi] = sh_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/sg_tick.sv
module sg_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = active && (cnt_q == LAST);
  assign cnt_en = 1'b1;

  always_comb begin
    if (!active || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sg_ramp.sv
module sg_ramp
  import stall_guard_pkg::*;
#(
  parameter int ACC_W     = 12,
  parameter int UP_STEP   = 14,
  parameter int DN_STEP   = 1,
  parameter int LO_LVL    = 140,
  parameter int HI_LVL    = 420,
  parameter int EDGE_DROP = 70
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active,
  input  logic   tick,
  input  logic   hall_edge,
  output phase_t phase_o,
  output logic   locked_o
);
  localparam int XW = ACC_W + 1;
  localparam logic [XW-1:0] UP_X    = XW'(UP_STEP);
  localparam logic [XW-1:0] DN_X    = XW'(DN_STEP);
  localparam logic [XW-1:0] HI_X    = XW'(HI_LVL);
  localparam logic [XW-1:0] FLOOR_X = XW'(LO_LVL + DN_STEP);
  localparam logic [XW-1:0] DROP_X  = XW'(EDGE_DROP);
  localparam logic [ACC_W-1:0] HI_A = ACC_W'(HI_LVL);
  localparam logic [ACC_W-1:0] LO_A = ACC_W'(LO_LVL);

  logic [ACC_W-1:0] acc_q, acc_d;
  phase_t           ph_q, ph_d;
  logic             lk_q, lk_d;
  logic [XW-1:0]    acc_x, up_sum, dn_dif, drop_dif;
  logic             at_top, at_floor, drop_sat;

  assign acc_x    = {1'b0, acc_q};
  assign up_sum   = acc_x + UP_X;
  assign dn_dif   = acc_x - DN_X;
  assign drop_dif = acc_x - DROP_X;
  assign at_top   = (up_sum >= HI_X);
  assign at_floor = (acc_x <= FLOOR_X);
  assign drop_sat = (acc_x <= DROP_X);

  always_comb begin
    acc_d = acc_q;
    ph_d  = ph_q;
    lk_d  = lk_q;
    if (!active) begin
      acc_d = '0;
      ph_d  = PH_ON;
      lk_d  = 1'b0;
    end else begin
      unique case (ph_q)
        PH_ON: begin
          if (hall_edge) begin
            // rotation seen: pull down and release the stall flag
            acc_d = drop_sat ? '0 : drop_dif[ACC_W-1:0];
            lk_d  = 1'b0;
          end else if (tick) begin
            if (at_top) begin
              acc_d = HI_A;
              ph_d  = PH_OFF;
              lk_d  = 1'b1;
            end else begin
              acc_d = up_sum[ACC_W-1:0];
            end
          end
        end
        PH_OFF: begin
          // edges are ignored here: drive is blocked, the rotor only coasts
          if (tick) begin
            if (at_floor) begin
              acc_d = LO_A;
              ph_d  = PH_ON;
            end else begin
              acc_d = dn_dif[ACC_W-1:0];
            end
          end
        end
        default: ph_d = PH_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= PH_ON;
      lk_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ph_q  <= ph_d;
      lk_q  <= lk_d;
    end
  end

  assign phase_o  = ph_q;
  assign locked_o = lk_q;
endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_guard_pkg::*;
#(
  parameter int ACC_W       = 12,
  parameter int TICK_DIV    = 4,
  parameter int UP_STEP     = 14,
  parameter int DN_STEP     = 1,
  parameter int LO_LVL      = 140,
  parameter int HI_LVL      = 420,
  parameter int EDGE_DROP   = 70,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_in,
  input  logic prot_en,
  input  logic run,
  output logic drive_ok,
  output logic locked
);
  logic [1:0] rs_q, rs_d;
  logic       rst_int_n;
  logic       active, tick, hall_edge;
  phase_t     phase;

  assign rs_d = {rs_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end
  assign rst_int_n = rs_q[1];

  assign active = run && prot_en;

  sg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (hall_in),
    .edge_o (hall_edge)
  );

  sg_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .active (active),
    .tick   (tick)
  );

  sg_ramp #(
    .ACC_W     (ACC_W),
    .UP_STEP   (UP_STEP),
    .DN_STEP   (DN_STEP),
    .LO_LVL    (LO_LVL),
    .HI_LVL    (HI_LVL),
    .EDGE_DROP (EDGE_DROP)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .active    (active),
    .tick      (tick),
    .hall_edge (hall_edge),
    .phase_o   (phase),
    .locked_o  (locked)
  );

  assign drive_ok = run && (phase == PH_ON);
endmodule

// File: rtl/stall_guard_chk.sv
module stall_guard_chk #(
  parameter int TICK_DIV = 4,
  parameter int UP_STEP  = 14,
  parameter int DN_STEP  = 1,
  parameter int LO_LVL   = 140,
  parameter int HI_LVL   = 420
) (
  input logic clk,
  input logic rst_n,
  input logic prot_en,
  input logic run,
  input logic drive_ok,
  input logic locked
);
  localparam int OFF_CYC = ((HI_LVL - LO_LVL + DN_STEP - 1) / DN_STEP) * TICK_DIV;
  localparam int ON_CYC  = ((HI_LVL - LO_LVL + UP_STEP - 1) / UP_STEP) * TICK_DIV;
  localparam int CW      = $clog2(OFF_CYC + 2);

  logic [CW-1:0] off_cnt, on_cnt;
  logic          in_off, in_retry;

  assign in_off   = run && prot_en && !drive_ok;
  assign in_retry = run && prot_en && drive_ok && locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt <= '0;
      on_cnt  <= '0;
    end else begin
      off_cnt <= in_off   ? off_cnt + 1'b1 : '0;
      on_cnt  <= in_retry ? on_cnt + 1'b1  : '0;
    end
  end

  p_stop_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !drive_ok);
  p_stop_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !locked);
  p_dis_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> (drive_ok == run));
  p_dis_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> !locked);
  p_off_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_off |-> locked);
  p_off_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    off_cnt <= CW'(OFF_CYC));
  p_on_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    on_cnt <= CW'(ON_CYC));
  p_lock_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !drive_ok);
endmodule

bind stall_guard stall_guard_chk #(
  .TICK_DIV (TICK_DIV),
  .UP_STEP  (UP_STEP),
  .DN_STEP  (DN_STEP),
  .LO_LVL   (LO_LVL),
  .HI_LVL   (HI_LVL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .prot_en  (prot_en),
  .run      (run),
  .drive_ok (drive_ok),
  .locked   (locked)
);

// File: tb/stall_guard_tb.sv
module stall_guard_tb;
  localparam int TICK_DIV  = 4;
  localparam int UP_STEP   = 14;
  localparam int DN_STEP   = 1;
  localparam int LO_LVL    = 140;
  localparam int HI_LVL    = 420;
  localparam int EDGE_DROP = 70;

  localparam int FIRST_CYC = ((HI_LVL + UP_STEP - 1) / UP_STEP) * TICK_DIV;
  localparam int OFF_CYC   = ((HI_LVL - LO_LVL + DN_STEP - 1) / DN_STEP) * TICK_DIV;
  localparam int RETRY_CYC = ((HI_LVL - LO_LVL + UP_STEP - 1) / UP_STEP) * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n, hall_in, prot_en, run;
  logic drive_ok, locked;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  stall_guard u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .hall_in  (hall_in),
    .prot_en  (prot_en),
    .run      (run),
    .drive_ok (drive_ok),
    .locked   (locked)
  );

  function automatic bit expect_lock(int period);
    return ((period / TICK_DIV) * UP_STEP) > EDGE_DROP;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // count clock edges while drive_ok keeps the given level
  task automatic measure(bit lvl, bit toggle, output int n);
    n = 0;
    while (drive_ok == lvl && n < 5000) begin
      @(posedge clk);
      #1;
      n++;
      if (toggle && (n % 16 == 8)) hall_in = ~hall_in;
    end
  endtask

  task automatic restart();
    run = 1'b0;
    step(2);
    run = 1'b1;
    #1;
  endtask

  initial begin
    int n;
    int bad;
    bit seen;
    void'($urandom(32'd1234));
    rst_n = 1'b0; hall_in = 1'b0; prot_en = 1'b1; run = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(4);

    chk("R11 locked after reset", locked, 0);
    chk("R11 drive after reset", drive_ok, 0);

    run = 1'b1;
    #1;
    chk("R3 drive at start", drive_ok, 1);
    measure(1'b1, 1'b0, n);
    chk("R3 first engagement length", n, FIRST_CYC);
    chk("R3 locked at engagement", locked, 1);
    measure(1'b0, 1'b0, n);
    chk("R4 off window length", n, OFF_CYC);
    chk("R5 locked in retry", locked, 1);
    measure(1'b1, 1'b0, n);
    chk("R5 retry window length", n, RETRY_CYC);
    measure(1'b0, 1'b1, n);
    chk("R6 off window with edges", n, OFF_CYC);
    chk("R6 locked held", locked, 1);

    // R9: edge inside the retry window
    hall_in = ~hall_in;
    step(2);
    chk("R9 locked before edge lands", locked, 1);
    step(1);
    chk("R9 locked cleared", locked, 0);
    chk("R9 drive kept", drive_ok, 1);

    // R7: fast rotation keeps running
    bad = 0;
    for (int i = 0; i < 1500; i++) begin
      if (i % 12 == 0) hall_in = ~hall_in;
      step(1);
      if (locked || !drive_ok) bad++;
    end
    chk("R7 fast edges no lock", bad, 0);

    // R8: slow rotation engages
    seen = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      if (i % 150 == 0) hall_in = ~hall_in;
      step(1);
      if (locked) seen = 1'b1;
    end
    chk("R8 slow edges lock", seen, 1);

    // R1: stop clears
    run = 1'b0;
    #1;
    chk("R1 drive in stop", drive_ok, 0);
    step(1);
    chk("R1 locked in stop", locked, 0);
    step(3);
    run = 1'b1;
    #1;
    measure(1'b1, 1'b0, n);
    chk("R1 restart from zero", n, FIRST_CYC);

    // R2: protection disabled
    run = 1'b0;
    step(2);
    prot_en = 1'b0;
    run = 1'b1;
    bad = 0;
    for (int i = 0; i < 1500; i++) begin
      step(1);
      if (locked || !drive_ok) bad++;
    end
    chk("R2 disabled never locks", bad, 0);
    run = 1'b0;
    #1;
    chk("R2 drive follows run", drive_ok, 0);
    run = 1'b1;
    step(1);
    prot_en = 1'b1;
    #1;
    measure(1'b1, 1'b0, n);
    chk("R2 re-enable from zero", n, FIRST_CYC);

    // R7/R8 random toggle periods
    for (int t = 0; t < 8; t++) begin
      int p;
      p = (t % 2 == 0) ? 4 + int'($urandom % 13) : 100 + int'($urandom % 101);
      restart();
      seen = 1'b0;
      for (int i = 0; i < 1200; i++) begin
        if (i % p == 0) hall_in = ~hall_in;
        step(1);
        if (locked) seen = 1'b1;
      end
      chk(expect_lock(p) ? "R8 random slow period" : "R7 random fast period",
          seen, expect_lock(p));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule